// File: doc/BRIEF.md
# Halt and Active-Halt Power Controller

This block sequences the low-power modes of a small microcontroller. When the CPU signals a halt, the block picks one of two sleep depths using the oscillator-interrupt enable bit. In active-halt the oscillator and its timebase keep running. In deep halt everything is stopped. The block drives the clock enables for the CPU, the peripherals and the oscillator. It forces the two interrupt-mask bits while in active-halt, and it masks watchdog resets for that period.

Wake-up from active-halt through the timebase interrupt is immediate. Every other exit passes through a stabilization wait of 256 or 4096 cycles, chosen by an option bit. At the end of that wait the block pulses one of two strobes. A reset-caused exit pulses the reset-vector-fetch strobe. An interrupt-caused exit pulses the resume strobe. All pins are plain level or strobe controls, and there is no streaming interface.

Top module: `halt_pwr_ctrl`

## Requirements
- R1: After `rst_n` is released the block is in run mode. `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, and `resume_irq`, `fetch_rst_vec`, `imask_force_en` and `wdg_rst_mask` are 0.
- R2: A `halt_req` in run mode while `osc_irq_en`=1 enters active-halt on the next cycle. In active-halt `osc_en`=1, `cpu_clk_en`=0, `per_clk_en`=0, `imask_force_en`=1 and `imask_force_val`=2'b10.
- R3: A `halt_req` in run mode while `osc_irq_en`=0 enters deep halt. In deep halt `osc_en`, `cpu_clk_en` and `per_clk_en` are all 0.
- R4: In active-halt, `tb_irq` (with no `rst_req`) returns the block to run mode on the next cycle, with no delay. `resume_irq` is 1 for exactly that first run cycle. A `tb_irq` already high on the entry cycle wakes the block one cycle after entry.
- R5: In active-halt, `ext_irq` is ignored and the block stays in active-halt.
- R6: In active-halt, `rst_req` starts the stabilization wait. The wait spans 256 cycles when `long_dly_sel`=0, counted up to the cycle in which `cpu_clk_en` returns to 1. In that cycle `fetch_rst_vec` is 1 for one cycle.
- R7: `wdg_rst_mask` is 1 exactly when the block is in active-halt and `wdg_active`=1.
- R8: In deep halt, `ext_irq` or `rst_req` starts the stabilization wait, and `tb_irq` is ignored. When the wait follows `ext_irq`, `resume_irq` (not `fetch_rst_vec`) pulses when the CPU clock returns. During the wait `osc_en`=1 and `cpu_clk_en`=0.
- R9: When `rst_req` and an interrupt request arrive in the same cycle, the exit is treated as a reset exit.
- R10: Clearing `osc_irq_en` while in active-halt moves the block to deep halt on the next cycle.
- R11: With `long_dly_sel`=1 at the start of the wait, the wait spans 4096 cycles.
- R12: `halt_req` is acted on only in run mode. During the wait, `halt_req`, `ext_irq` and `rst_req` change neither its length nor the exit cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| halt_req | input | 1 | Halt instruction strobe from the CPU |
| osc_irq_en | input | 1 | Oscillator-interrupt enable; selects active-halt (1) or deep halt (0) |
| tb_irq | input | 1 | Timebase interrupt request |
| ext_irq | input | 1 | Any external or peripheral interrupt request |
| rst_req | input | 1 | System reset request |
| wdg_active | input | 1 | Watchdog running flag |
| long_dly_sel | input | 1 | Option bit: 1 selects the 4096-cycle wait, 0 the 256-cycle wait |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Main oscillator enable |
| imask_force_en | output | 1 | Interrupt-mask override active |
| imask_force_val | output | 2 | Value forced onto the interrupt-mask bits |
| wdg_rst_mask | output | 1 | Blocks the watchdog reset |
| resume_irq | output | 1 | One-cycle strobe: resume by servicing an interrupt |
| fetch_rst_vec | output | 1 | One-cycle strobe: fetch the reset vector |

## Verification
The assertions check the state transitions on every cycle. These cover the choice of sleep depth, the immediate timebase wake, the rule that a reset outranks an interrupt, and the decrement of the wait counter. They also check that the two exit strobes never overlap. Only the bench scenarios can show that the waits last exactly 256 and 4096 cycles end to end. They also show that ignored inputs leave the outputs unchanged, and that the exit cause chosen at the start of a long wait is the strobe that finally appears.

// File: rtl/halt_pwr_pkg.sv
package halt_pwr_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_AHALT = 2'd1,
    ST_HALT  = 2'd2,
    ST_WAKE  = 2'd3
  } pwr_state_e;

  localparam logic [1:0] IMASK_IRQ_ON = 2'b10;
endpackage

// File: rtl/hpc_delay_cnt.sv
module hpc_delay_cnt #(
  parameter int SHORT_DLY = 256,
  parameter int LONG_DLY  = 4096,
  localparam int CW = $clog2(LONG_DLY)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic long_sel,
  output logic done
);
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_DLY - 1);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_DLY - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= long_sel ? LONG_LD : SHORT_LD;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R6
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && long_sel) |=> (cnt == LONG_LD)); // R11
endmodule

// File: rtl/hpc_fsm.sv
module hpc_fsm
  import halt_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic       osc_irq_en,
  input  logic       tb_irq,
  input  logic       ext_irq,
  input  logic       rst_req,
  input  logic       dly_done,
  output logic       dly_load,
  output pwr_state_e state,
  output logic       resume_irq,
  output logic       fetch_rst_vec
);
  pwr_state_e nxt;
  logic       cause_rst, cause_rst_nxt;
  logic       resume_nxt, fetch_nxt;

  always_comb begin
    nxt           = state;
    cause_rst_nxt = cause_rst;
    resume_nxt    = 1'b0;
    fetch_nxt     = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (halt_req) nxt = osc_irq_en ? ST_AHALT : ST_HALT;
      end
      ST_AHALT: begin
        if (rst_req) begin
          nxt           = ST_WAKE;
          cause_rst_nxt = 1'b1;
        end else if (tb_irq) begin
          nxt        = ST_RUN;
          resume_nxt = 1'b1;
        end else if (!osc_irq_en) begin
          nxt = ST_HALT;
        end
      end
      ST_HALT: begin
        if (rst_req || ext_irq) begin
          nxt           = ST_WAKE;
          cause_rst_nxt = rst_req;
        end
      end
      ST_WAKE: begin
        if (dly_done) begin
          nxt        = ST_RUN;
          fetch_nxt  = cause_rst;
          resume_nxt = !cause_rst;
        end
      end
      default: nxt = ST_RUN;
    endcase
  end

  assign dly_load = (nxt == ST_WAKE) && (state != ST_WAKE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_RUN;
      cause_rst     <= 1'b0;
      resume_irq    <= 1'b0;
      fetch_rst_vec <= 1'b0;
    end else begin
      state         <= nxt;
      cause_rst     <= cause_rst_nxt;
      resume_irq    <= resume_nxt;
      fetch_rst_vec <= fetch_nxt;
    end
  end

  AST_ENTER_AHALT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && halt_req && osc_irq_en) |=> (state == ST_AHALT)); // R2
  AST_ENTER_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && halt_req && !osc_irq_en) |=> (state == ST_HALT)); // R3
  AST_TB_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AHALT && tb_irq && !rst_req) |=> (state == ST_RUN && resume_irq)); // R4
  AST_EXT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AHALT && ext_irq && !tb_irq && !rst_req && osc_irq_en) |=> (state == ST_AHALT)); // R5
  AST_RST_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AHALT && rst_req) |=> (state == ST_WAKE && !resume_irq)); // R9
  AST_OIE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AHALT && !osc_irq_en && !tb_irq && !rst_req) |=> (state == ST_HALT)); // R10
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resume_irq, fetch_rst_vec})); // R8
endmodule

// File: rtl/hpc_out_dec.sv
module hpc_out_dec
  import halt_pwr_pkg::*;
(
  input  pwr_state_e state,
  input  logic       wdg_active,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_en,
  output logic       imask_force_en,
  output logic [1:0] imask_force_val,
  output logic       wdg_rst_mask
);
  always_comb begin
    cpu_clk_en      = (state == ST_RUN);
    per_clk_en      = (state == ST_RUN);
    osc_en          = (state != ST_HALT);
    imask_force_en  = (state == ST_AHALT);
    imask_force_val = (state == ST_AHALT) ? IMASK_IRQ_ON : 2'b00;
    wdg_rst_mask    = (state == ST_AHALT) && wdg_active;
  end

  always_comb begin
    if (imask_force_en) AST_FORCE_MASK: assert (osc_en && !cpu_clk_en); // R2
  end
endmodule

// File: rtl/halt_pwr_ctrl.sv
module halt_pwr_ctrl
  import halt_pwr_pkg::*;
#(
  parameter int SHORT_DLY = 256,
  parameter int LONG_DLY  = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic       osc_irq_en,
  input  logic       tb_irq,
  input  logic       ext_irq,
  input  logic       rst_req,
  input  logic       wdg_active,
  input  logic       long_dly_sel,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_en,
  output logic       imask_force_en,
  output logic [1:0] imask_force_val,
  output logic       wdg_rst_mask,
  output logic       resume_irq,
  output logic       fetch_rst_vec
);
  pwr_state_e state;
  logic       dly_load, dly_done;

  hpc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .osc_irq_en(osc_irq_en),
    .tb_irq(tb_irq), .ext_irq(ext_irq), .rst_req(rst_req), .dly_done(dly_done),
    .dly_load(dly_load), .state(state), .resume_irq(resume_irq),
    .fetch_rst_vec(fetch_rst_vec)
  );

  hpc_delay_cnt #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_dly (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .long_sel(long_dly_sel),
    .done(dly_done)
  );

  hpc_out_dec u_dec (
    .state(state), .wdg_active(wdg_active), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .osc_en(osc_en), .imask_force_en(imask_force_en),
    .imask_force_val(imask_force_val), .wdg_rst_mask(wdg_rst_mask)
  );

  AST_WAKE_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en) |-> (!cpu_clk_en && !per_clk_en)); // R3
endmodule

// File: tb/test_halt_pwr_ctrl.sv
`timescale 1ns/100ps
module test_halt_pwr_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, osc_irq_en = 0, tb_irq = 0, ext_irq = 0, rst_req = 0;
  logic wdg_active = 1, long_dly_sel = 0;
  logic cpu_clk_en, per_clk_en, osc_en, imask_force_en, wdg_rst_mask;
  logic resume_irq, fetch_rst_vec;
  logic [1:0] imask_force_val;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  halt_pwr_ctrl i_halt_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .osc_irq_en(osc_irq_en),
    .tb_irq(tb_irq), .ext_irq(ext_irq), .rst_req(rst_req), .wdg_active(wdg_active),
    .long_dly_sel(long_dly_sel), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_en(osc_en), .imask_force_en(imask_force_en), .imask_force_val(imask_force_val),
    .wdg_rst_mask(wdg_rst_mask), .resume_irq(resume_irq), .fetch_rst_vec(fetch_rst_vec)
  );

  // {halt, oie, tb, ext, rst, exp cpu, exp per, exp osc, exp wdg mask, exp resume}
  localparam int NV = 8;
  localparam logic [9:0] VEC [NV] = '{
    10'b11000_00110, // R2 enter active-halt
    10'b01010_00110, // R5 ext ignored
    10'b01100_11101, // R4 timebase wake
    10'b01000_11100, // R4 resume strobe ends
    10'b10000_00000, // R3 enter deep halt
    10'b00100_00000, // R8 tb ignored in deep halt
    10'b11000_00000, // R12 halt ignored outside run
    10'b00010_00100  // R8 ext starts wait
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic h, o, t, e, r);
    halt_req = h; osc_irq_en = o; tb_irq = t; ext_irq = e; rst_req = r;
  endtask

  task automatic count_wait(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!cpu_clk_en && n < 5000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 enables", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
    chk("R1 strobes", {resume_irq, fetch_rst_vec, imask_force_en, wdg_rst_mask}, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5]);
      step();
      chk($sformatf("R7 vec%0d outputs", i),
          {cpu_clk_en, per_clk_en, osc_en, wdg_rst_mask, resume_irq}, VEC[i][4:0]);
      if (i == 0) chk("R2 mask force", {imask_force_en, imask_force_val}, 3'b110);
    end

    drive(0, 0, 0, 0, 0);
    count_wait(n);
    chk("R8 short wait length", n, 256);
    chk("R8 resume after ext wait", {resume_irq, fetch_rst_vec}, 2'b10);

    // R4: timebase already pending at entry
    drive(1, 1, 1, 0, 0);
    step();
    chk("R4 entered active-halt", {cpu_clk_en, osc_en}, 2'b01);
    drive(0, 1, 1, 0, 0);
    step();
    chk("R4 pending wake", {cpu_clk_en, resume_irq}, 2'b11);

    // R9 R11 R6: reset+timebase together, long wait
    drive(1, 1, 0, 0, 0);
    step();
    long_dly_sel = 1;
    drive(0, 1, 1, 1, 1);
    step();
    chk("R9 reset wins", {cpu_clk_en, osc_en, resume_irq}, 3'b010);
    drive(0, 1, 0, 0, 0);
    long_dly_sel = 0;
    count_wait(n);
    chk("R11 long wait length", n, 4096);
    chk("R6 fetch strobe", {fetch_rst_vec, resume_irq}, 2'b10);
    step();
    chk("R6 fetch one cycle", fetch_rst_vec, 0);

    // R10: clearing enable in active-halt
    drive(1, 1, 0, 0, 0);
    step();
    drive(0, 0, 0, 0, 0);
    step();
    chk("R10 moved to deep halt", {osc_en, wdg_rst_mask}, 2'b00);

    // R12: inputs during wait do not change length or cause
    drive(0, 0, 0, 0, 1);
    step();
    drive(1, 1, 0, 1, 1);
    count_wait(n);
    chk("R12 wait length unchanged", n, 256);
    chk("R12 cause kept", {fetch_rst_vec, resume_irq}, 2'b10);
    drive(0, 0, 0, 0, 0);

    // R7: watchdog mask follows wdg_active
    wdg_active = 0;
    drive(1, 1, 0, 0, 0);
    step();
    chk("R7 mask off when watchdog idle", wdg_rst_mask, 0);
    wdg_active = 1;
    #1;
    chk("R7 mask on in active-halt", wdg_rst_mask, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule